// File: doc/BRIEF.md
# Three-Phase PWM Pattern Transfer and Dead-Time Trigger Unit

This unit decides when the next six-bit phase pattern, held in two staging buffers, is copied into the twelve-bit output shift register of a three-phase PWM generator. It also produces the pulse that starts the dead-time timer. A transfer trigger can come from three sources: a carrier timer underflow, a software write of 1 to a trigger bit, or a write to the carrier timer register while that register's trigger enable is set. Sources that occur in the same clock are merged into one trigger.

Two modulation modes are supported. In triangular mode each buffer write arms one transfer, and later triggers do nothing until a buffer is written again. The dead-time timer starts only on the falling edge of any of the three one-shot pulses. In sawtooth mode every trigger causes a transfer, and every trigger also starts the dead-time timer, together with the one-shot falling edges. The mode bit only changes while the surrounding timers report idle.

Top module: `pwm_xfer_trigger`

## Requirements
- R1: After reset `shiftLoad`, `deadTrig`, `shiftPattern` and `modeSaw` are 0. Mode 0 is triangular and mode 1 is sawtooth. No transfer is armed.
- R2: A transfer trigger occurs in a cycle with `timerUnderflow`=1, or with `swTrigWrite`=1 and `swTrigData`=1, or with `carrierWrite`=1 and `carrierTrigEn`=1. A software write of 0, or a carrier write with the enable at 0, is not a trigger.
- R3: `swTrigRead` always reads 0.
- R4: In triangular mode a trigger causes a transfer only if a buffer write occurred after the last transfer. After one transfer, further triggers cause none until the next buffer write.
- R5: In sawtooth mode every trigger causes a transfer.
- R6: A transfer loads `shiftPattern` with buffer 1 in bits [11:6] and buffer 0 in bits [5:0]. It uses the contents the buffers held before the trigger cycle. `shiftPattern` holds its value between transfers.
- R7: In triangular mode `deadTrig` pulses one cycle after a 1-to-0 change of any bit of `oneShot`, and never because of a transfer trigger.
- R8: In sawtooth mode `deadTrig` pulses one cycle after any trigger and one cycle after any `oneShot` falling edge.
- R9: `modeWrite` loads `modeData` into the mode only when `timersIdle`=1. Otherwise the write is ignored.
- R10: Triggers from several sources in one cycle give one single-cycle `shiftLoad` pulse. Coinciding dead-time causes give one single-cycle `deadTrig` pulse.
- R11: `shiftLoad`, `shiftPattern` and `deadTrig` change on the clock edge that ends the triggering cycle.
- R12: A buffer write in the same cycle as a transfer arms a new transfer. The new data is moved by the next trigger in triangular mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| timerUnderflow | input | 1 | Carrier timer underflow pulse |
| swTrigWrite | input | 1 | Write strobe for the software trigger bit |
| swTrigData | input | 1 | Value written to the software trigger bit |
| swTrigRead | output | 1 | Read value of the software trigger bit (always 0) |
| carrierWrite | input | 1 | Write strobe for the carrier timer register |
| carrierTrigEn | input | 1 | Enable for the carrier-write trigger |
| buf0Write | input | 1 | Write strobe for buffer 0 |
| buf1Write | input | 1 | Write strobe for buffer 1 |
| bufData | input | 6 | Data for buffer writes |
| modeWrite | input | 1 | Write strobe for the mode bit |
| modeData | input | 1 | New mode: 0 triangular, 1 sawtooth |
| timersIdle | input | 1 | The associated timers are idle |
| oneShot | input | 3 | Levels of the three one-shot pulses |
| modeSaw | output | 1 | Current mode |
| shiftLoad | output | 1 | Shift register load pulse |
| shiftPattern | output | 12 | Pattern held by the shift register |
| deadTrig | output | 1 | Dead-time timer start pulse |

## Verification
The bench checks the one-shot arming in triangular mode. It fires repeated triggers after a single write, and a design without the arming flag would reload on every one. It also hits a buffer write in the same cycle as a transfer, where clearing the flag last would lose the new data. Software writes of 0 and carrier writes with the enable off are applied, and a design that decodes the strobe alone would load spuriously. Triggers are also applied in triangular mode, where a design that ignores the mode would pulse the dead-time output. Mode writes while the timers are busy would flip the mode if not gated. Three sources fire together, and a design that counted them would stretch or repeat the pulse.

// File: rtl/pwm_xfer_pkg.sv
package pwm_xfer_pkg;

  // Strobes passed from control to datapath in one cycle.
  typedef struct packed {
    logic loadShift;  // copy both buffers into the shift register
    logic wrBuf0;     // capture bufData into buffer 0
    logic wrBuf1;     // capture bufData into buffer 1
  } xferStrobe_t;

endpackage

// File: rtl/pwm_xfer_ctrl.sv
module pwm_xfer_ctrl
  import pwm_xfer_pkg::*;
#(
  parameter int NUM_ONESHOT = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   timerUnderflow,
  input  logic                   swTrigWrite,
  input  logic                   swTrigData,
  input  logic                   carrierWrite,
  input  logic                   carrierTrigEn,
  input  logic                   buf0Write,
  input  logic                   buf1Write,
  input  logic                   modeWrite,
  input  logic                   modeData,
  input  logic                   timersIdle,
  input  logic [NUM_ONESHOT-1:0] oneShot,
  output logic                   modeSaw,
  output logic                   deadTrig,
  output xferStrobe_t            strobe
);

  logic                   xferTrig;
  logic                   armed;
  logic                   bufWrite;
  logic                   loadNow;
  logic [NUM_ONESHOT-1:0] shotPrev;
  logic [NUM_ONESHOT-1:0] shotFall;
  logic                   anyFall;

  // All trigger sources collapse into one level for this cycle.
  assign xferTrig = timerUnderflow
                  | (swTrigWrite & swTrigData)
                  | (carrierWrite & carrierTrigEn);

  assign bufWrite = buf0Write | buf1Write;
  assign loadNow  = xferTrig & (modeSaw | armed);

  // Per-input falling-edge detectors.
  for (genvar g = 0; g < NUM_ONESHOT; g++) begin : g_fall
    assign shotFall[g] = shotPrev[g] & ~oneShot[g];
  end
  assign anyFall = |shotFall;

  always_comb begin
    strobe           = '0;
    strobe.loadShift = loadNow;
    strobe.wrBuf0    = buf0Write;
    strobe.wrBuf1    = buf1Write;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      modeSaw  <= 1'b0;
      shotPrev <= '0;
      deadTrig <= 1'b0;
    end else begin
      // A write re-arms even when it coincides with the transfer it follows.
      if (bufWrite)     armed <= 1'b1;
      else if (loadNow) armed <= 1'b0;
      if (modeWrite && timersIdle) modeSaw <= modeData;
      shotPrev <= oneShot;
      deadTrig <= anyFall | (modeSaw & xferTrig);
    end
  end

  // R9: without an accepted mode write the mode holds.
  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(modeWrite && timersIdle) |=> $stable(modeSaw));

  // R4: a triangular transfer without a write in its cycle is not followed by another.
  a_r4_tri_once: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadShift && !modeSaw && !bufWrite) |=> !strobe.loadShift);

  // R7: in triangular mode the dead-time pulse stems from a one-shot edge only.
  a_r7_tri_dead: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSaw && !anyFall) |=> !deadTrig);

  // R8: in sawtooth mode an underflow always starts the dead-time timer.
  a_r8_saw_dead: assert property (@(posedge clk) disable iff (!rstN)
    (modeSaw && timerUnderflow) |=> deadTrig);

endmodule

// File: rtl/pwm_xfer_datapath.sv
module pwm_xfer_datapath
  import pwm_xfer_pkg::*;
#(
  parameter int PHASES = 6,
  localparam int PAT_W = 2 * PHASES
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferStrobe_t       strobe,
  input  logic [PHASES-1:0] bufData,
  output logic              shiftLoad,
  output logic [PAT_W-1:0]  shiftPattern
);

  logic [PHASES-1:0] buf0;
  logic [PHASES-1:0] buf1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      buf0         <= '0;
      buf1         <= '0;
      shiftLoad    <= 1'b0;
      shiftPattern <= '0;
    end else begin
      if (strobe.wrBuf0) buf0 <= bufData;
      if (strobe.wrBuf1) buf1 <= bufData;
      shiftLoad <= strobe.loadShift;
      if (strobe.loadShift) shiftPattern <= {buf1, buf0};
    end
  end

  // R6: without a load the pattern is held.
  a_r6_pattern_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadShift |=> $stable(shiftPattern));

  // R6: a load places buffer 0 in the low half.
  a_r6_low_half: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadShift |=> shiftPattern[PHASES-1:0] == $past(buf0));

endmodule

// File: rtl/pwm_xfer_trigger.sv
module pwm_xfer_trigger
  import pwm_xfer_pkg::*;
#(
  parameter int PHASES      = 6,
  parameter int NUM_ONESHOT = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   timerUnderflow,
  input  logic                   swTrigWrite,
  input  logic                   swTrigData,
  output logic                   swTrigRead,
  input  logic                   carrierWrite,
  input  logic                   carrierTrigEn,
  input  logic                   buf0Write,
  input  logic                   buf1Write,
  input  logic [PHASES-1:0]      bufData,
  input  logic                   modeWrite,
  input  logic                   modeData,
  input  logic                   timersIdle,
  input  logic [NUM_ONESHOT-1:0] oneShot,
  output logic                   modeSaw,
  output logic                   shiftLoad,
  output logic [2*PHASES-1:0]    shiftPattern,
  output logic                   deadTrig
);

  xferStrobe_t strobe;

  // The trigger bit is write-only.
  assign swTrigRead = 1'b0;

  pwm_xfer_ctrl #(.NUM_ONESHOT(NUM_ONESHOT)) i_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .timerUnderflow (timerUnderflow),
    .swTrigWrite    (swTrigWrite),
    .swTrigData     (swTrigData),
    .carrierWrite   (carrierWrite),
    .carrierTrigEn  (carrierTrigEn),
    .buf0Write      (buf0Write),
    .buf1Write      (buf1Write),
    .modeWrite      (modeWrite),
    .modeData       (modeData),
    .timersIdle     (timersIdle),
    .oneShot        (oneShot),
    .modeSaw        (modeSaw),
    .deadTrig       (deadTrig),
    .strobe         (strobe)
  );

  pwm_xfer_datapath #(.PHASES(PHASES)) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .bufData      (bufData),
    .shiftLoad    (shiftLoad),
    .shiftPattern (shiftPattern)
  );

  // R5: in sawtooth mode an underflow always loads the shift register.
  a_r5_saw_load: assert property (@(posedge clk) disable iff (!rstN)
    (modeSaw && timerUnderflow) |=> shiftLoad);

  // R11: a load pulse is preceded by a trigger cause in the previous cycle.
  a_r11_load_cause: assert property (@(posedge clk) disable iff (!rstN)
    shiftLoad |-> $past(timerUnderflow || (swTrigWrite && swTrigData)
                        || (carrierWrite && carrierTrigEn)));

endmodule

// File: tb/test_pwm_xfer_trigger.sv
module test_pwm_xfer_trigger;

  localparam int PH = 6;
  localparam int NS = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          timerUnderflow = 0, swTrigWrite = 0, swTrigData = 0;
  logic          carrierWrite = 0, carrierTrigEn = 0;
  logic          buf0Write = 0, buf1Write = 0;
  logic [PH-1:0] bufData = '0;
  logic          modeWrite = 0, modeData = 0, timersIdle = 1;
  logic [NS-1:0] oneShot = '0;
  logic          swTrigRead, modeSaw, shiftLoad, deadTrig;
  logic [2*PH-1:0] shiftPattern;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Reference model state
  bit [PH-1:0]   mBuf0, mBuf1;
  bit            mArmed, mSaw;
  bit [NS-1:0]   mPrev;
  bit            eLoad, eDead;
  bit [2*PH-1:0] ePat;

  pwm_xfer_trigger #(.PHASES(PH), .NUM_ONESHOT(NS)) i_pwm_xfer_trigger (
    .clk(clk), .rstN(rstN), .timerUnderflow(timerUnderflow),
    .swTrigWrite(swTrigWrite), .swTrigData(swTrigData), .swTrigRead(swTrigRead),
    .carrierWrite(carrierWrite), .carrierTrigEn(carrierTrigEn),
    .buf0Write(buf0Write), .buf1Write(buf1Write), .bufData(bufData),
    .modeWrite(modeWrite), .modeData(modeData), .timersIdle(timersIdle),
    .oneShot(oneShot), .modeSaw(modeSaw), .shiftLoad(shiftLoad),
    .shiftPattern(shiftPattern), .deadTrig(deadTrig)
  );

  always #10 clk = ~clk;  // 50 MHz

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // One cycle: model reacts to the inputs now applied, then compare after the edge.
  task automatic step(string tag);
    bit trig, load, fall;
    trig = timerUnderflow | (swTrigWrite & swTrigData) | (carrierWrite & carrierTrigEn);
    load = trig && (mSaw || mArmed);
    fall = |(mPrev & ~oneShot);
    eLoad = load;
    eDead = fall | (mSaw & trig);
    if (load) ePat = {mBuf1, mBuf0};
    if (buf0Write) mBuf0 = bufData;
    if (buf1Write) mBuf1 = bufData;
    if (buf0Write || buf1Write) mArmed = 1'b1;
    else if (load)              mArmed = 1'b0;
    mPrev = oneShot;
    if (modeWrite && timersIdle) mSaw = modeData;
    @(posedge clk);
    @(negedge clk);
    check({tag, mSaw ? " R5" : " R4"}, "shiftLoad", shiftLoad, eLoad);
    check({tag, " R6"}, "shiftPattern", shiftPattern, ePat);
    check({tag, mSaw ? " R8" : " R7"}, "deadTrig", deadTrig, eDead);
    check({tag, " R9"}, "modeSaw", modeSaw, mSaw);
    check({tag, " R3"}, "swTrigRead", swTrigRead, 0);
    timerUnderflow = 0; swTrigWrite = 0; swTrigData = 0; carrierWrite = 0;
    buf0Write = 0; buf1Write = 0; modeWrite = 0;
  endtask

  task automatic wrBufs(logic [PH-1:0] d0, logic [PH-1:0] d1);
    buf0Write = 1; bufData = d0; step("wr0");
    buf1Write = 1; bufData = d1; step("wr1");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
        finishRun();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "shiftLoad", shiftLoad, 0);
    check("R1", "deadTrig", deadTrig, 0);
    check("R1", "shiftPattern", shiftPattern, 0);
    check("R1", "modeSaw", modeSaw, 0);
    timerUnderflow = 1; step("R1 no armed transfer");

    // R4 R6 R11: one transfer per write in triangular mode
    wrBufs(6'h15, 6'h2A);
    timerUnderflow = 1; step("R4 R6 R11 first trigger");
    timerUnderflow = 1; step("R4 second trigger");
    swTrigWrite = 1; swTrigData = 1; step("R4 third trigger");
    step("R4 idle");

    // R2: trigger sources and non-triggers
    wrBufs(6'h01, 6'h3E);
    swTrigWrite = 1; swTrigData = 0; step("R2 sw write 0");
    carrierWrite = 1; carrierTrigEn = 0; step("R2 carrier no enable");
    swTrigWrite = 1; swTrigData = 1; step("R2 sw write 1");
    wrBufs(6'h22, 6'h11);
    carrierWrite = 1; carrierTrigEn = 1; step("R2 carrier enabled");
    carrierTrigEn = 0;

    // R12: buffer write coinciding with a transfer
    buf0Write = 1; bufData = 6'h0F; step("R12 arm");
    timerUnderflow = 1; buf1Write = 1; bufData = 6'h30; step("R12 write with transfer");
    timerUnderflow = 1; step("R12 next trigger loads new");
    timerUnderflow = 1; step("R12 then disarmed");

    // R10: merged sources
    wrBufs(6'h2D, 6'h12);
    timerUnderflow = 1; swTrigWrite = 1; swTrigData = 1;
    carrierWrite = 1; carrierTrigEn = 1; step("R10 three sources");
    carrierTrigEn = 0;
    step("R10 single pulse");

    // R7: dead-time in triangular mode
    oneShot = 3'b101; step("R7 rise");
    oneShot = 3'b001; step("R7 fall bit2");
    oneShot = 3'b000; step("R7 fall bit0");
    timerUnderflow = 1; step("R7 trigger no dead");
    oneShot = 3'b111; step("R7 rise all");
    oneShot = 3'b000; step("R7 R10 fall all one pulse");

    // R9: mode write ignored while busy
    timersIdle = 0; modeWrite = 1; modeData = 1; step("R9 busy write");
    step("R9 hold");
    timersIdle = 1; modeWrite = 1; modeData = 1; step("R9 idle write");

    // R5 R8: sawtooth mode
    wrBufs(6'h07, 6'h38);
    timerUnderflow = 1; step("R5 R8 underflow");
    timerUnderflow = 1; step("R5 R8 underflow again");
    swTrigWrite = 1; swTrigData = 1; step("R5 R8 sw trigger");
    buf0Write = 1; bufData = 6'h3F; step("R5 write only");
    carrierWrite = 1; carrierTrigEn = 1; step("R5 carrier");
    carrierTrigEn = 0;
    oneShot = 3'b010; step("R8 rise");
    oneShot = 3'b000; timerUnderflow = 1; step("R8 R10 fall with trigger");
    swTrigWrite = 1; swTrigData = 0; step("R2 R8 sw write 0");
    step("R8 idle");

    // back to triangular: armed flag was cleared by the last transfer
    modeWrite = 1; modeData = 0; step("R9 back to triangular");
    timerUnderflow = 1; step("R4 no rearm");
    repeat (2) step("tail");
    finishRun();
  end

endmodule